// File: doc/BRIEF.md
# Dual Parallel Port Adapter with Direction Control

This block connects two 8-bit general-purpose pin groups, port A and port B, to a narrow host bus. The host sees four addresses, chosen by a 2-bit register select. Behind them sit six registers: an output latch, a direction register and a control register for each port. Bit 2 of a port's control register steers that port's data-side address. When the bit is set, the address reaches the output latch and the pin view. When it is clear, the same address reaches the direction register.

Every pin is modelled as three separate signals: a live input value, an output value and an output enable. Each direction bit decides whether its pin is driven. A read of the port returns the latch for driven bits and the live pin for undriven ones. A transfer needs chip select and the enable strobe together. Writes are captured on the rising clock edge. Read data is combinational and returns zero outside a qualified read.

Top module: `pio_dual_port`

## Requirements
- R1: An active-low reset, applied asynchronously, clears every latch, direction register and control register to 0x00. All output enables and outputs are then 0.
- R2: Register select 0 is the port A data side, 1 is control A, 2 is the port B data side and 3 is control B. Control registers read back all 8 bits as written.
- R3: While bit 2 of a port's control register is 0, that port's data-side address writes and reads its direction register.
- R4: While bit 2 of a port's control register is 1, a data-side write loads the output latch and leaves the direction register unchanged.
- R5: Output enable bit i equals direction bit i. The output bit equals the latch bit when direction bit i is 1, and is 0 when it is 0.
- R6: A read of the port data side returns the latch bit for each bit whose direction is 1, and the live input pin for each bit whose direction is 0.
- R7: A latch write takes effect whatever the direction setting. The value appears on the pins once the direction bits are later set.
- R8: The read data bus is 0x00 unless chip select, enable and read are all high together.
- R9: A write happens only on a rising clock edge with chip select and enable high and the read/write line low (1 = read, 0 = write). Otherwise no register changes.
- R10: Accesses to one port never change the other port's registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Chip select, active high |
| bus_en | input | 1 | Transfer enable strobe, active high |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_rs | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when not reading |
| pa_in | input | 8 | Port A live pin values |
| pa_out | output | 8 | Port A driven values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B live pin values |
| pb_out | output | 8 | Port B driven values |
| pb_oe | output | 8 | Port B output enables |

## Verification
A wrong direction register shows up at once on the output enables, and on the next read as a pin value mixed from the wrong sources. A wrong control bit 2 shows only at the next access to the data side, which then reaches the wrong register. A readback of the direction register that returns the latch value, or the reverse, exposes it within one write/read pair. A latch error can stay hidden while its bits are inputs. It appears only when the direction is later switched, so the tests write the latch with the pins undriven and then turn the outputs on.

// File: rtl/pio_pkg.sv
package pio_pkg;
  // bit of a control register that steers the data-side address
  localparam int ROUTE_BIT = 2;

  typedef enum logic [1:0] {
    VIEW_PINS = 2'd0,
    VIEW_DIR  = 2'd1,
    VIEW_CTRL = 2'd2
  } view_e;
endpackage

// File: rtl/pio_regsel.sv
module pio_regsel
  import pio_pkg::*;
#(
  parameter int NPORT = 2,
  localparam int IDXW = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int SELW = IDXW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              en,
  input  logic              rw,
  input  logic [SELW-1:0]   rs,
  input  logic [NPORT-1:0]  route,
  output logic [NPORT-1:0]  wr_dat,
  output logic [NPORT-1:0]  wr_dir,
  output logic [NPORT-1:0]  wr_ctl,
  output logic              rd_go,
  output logic [IDXW-1:0]   rd_idx,
  output view_e             rd_view
);
  logic            acc_go;
  logic            wr_go;
  logic            is_ctl;
  logic [IDXW-1:0] sel_idx;

  assign acc_go  = cs && en;
  assign wr_go   = acc_go && !rw;
  assign rd_go   = acc_go && rw;
  assign is_ctl  = rs[0];
  assign sel_idx = rs[SELW-1:1];
  assign rd_idx  = sel_idx;

  for (genvar p = 0; p < NPORT; p++) begin : g_strobe
    logic hit;
    assign hit       = wr_go && (sel_idx == IDXW'(p));
    assign wr_ctl[p] = hit && is_ctl;
    assign wr_dat[p] = hit && !is_ctl && route[p];
    assign wr_dir[p] = hit && !is_ctl && !route[p];
  end

  always_comb begin
    if (is_ctl)               rd_view = VIEW_CTRL;
    else if (route[sel_idx])  rd_view = VIEW_PINS;
    else                      rd_view = VIEW_DIR;
  end

  // R2
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_dat, wr_dir, wr_ctl}));
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_dat,
  input  logic         wr_dir,
  input  logic         wr_ctl,
  input  logic [W-1:0] wdat,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] view_pins,
  output logic [W-1:0] view_dir,
  output logic [W-1:0] view_ctl,
  output logic         route
);
  logic [W-1:0] lat_q;
  logic [W-1:0] dir_q;
  logic [W-1:0] ctl_q;

  // driven bits come from the latch, the rest are held at zero
  function automatic logic [W-1:0] drive_of(logic [W-1:0] lat, logic [W-1:0] dir);
    return lat & dir;
  endfunction

  // readback: latch where driven, live pin where undriven
  function automatic logic [W-1:0] merge_of(logic [W-1:0] lat, logic [W-1:0] dir,
                                            logic [W-1:0] pin);
    return (lat & dir) | (pin & ~dir);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '0;
      ctl_q <= '0;
    end else begin
      if (wr_dat) lat_q <= wdat;
      if (wr_dir) dir_q <= wdat;
      if (wr_ctl) ctl_q <= wdat;
    end
  end

  assign pin_out   = drive_of(lat_q, dir_q);
  assign pin_oe    = dir_q;
  assign view_pins = merge_of(lat_q, dir_q, pin_in);
  assign view_dir  = dir_q;
  assign view_ctl  = ctl_q;
  assign route     = ctl_q[ROUTE_BIT];

  // R3
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (dir_q == $past(wdat)) && $stable(lat_q));

  // R4
  lat_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat |=> (lat_q == $past(wdat)) && $stable(dir_q));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_dat || wr_dir || wr_ctl) |=> $stable(lat_q) && $stable(dir_q) && $stable(ctl_q));

  // R5
  oe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_oe) |-> $past(wr_dir));
endmodule

// File: rtl/pio_dual_port.sv
module pio_dual_port
  import pio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_cs,
  input  logic         bus_en,
  input  logic         bus_rw,
  input  logic [1:0]   bus_rs,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pa_in,
  output logic [W-1:0] pa_out,
  output logic [W-1:0] pa_oe,
  input  logic [W-1:0] pb_in,
  output logic [W-1:0] pb_out,
  output logic [W-1:0] pb_oe
);
  localparam int NPORT = 2;
  localparam int IDXW  = 1;

  logic [NPORT-1:0] wr_dat, wr_dir, wr_ctl, route;
  logic             rd_go;
  logic [IDXW-1:0]  rd_idx;
  view_e            rd_view;

  logic [W-1:0] pin_in_v  [NPORT];
  logic [W-1:0] pin_out_v [NPORT];
  logic [W-1:0] pin_oe_v  [NPORT];
  logic [W-1:0] vpin_v    [NPORT];
  logic [W-1:0] vdir_v    [NPORT];
  logic [W-1:0] vctl_v    [NPORT];

  assign pin_in_v[0] = pa_in;
  assign pin_in_v[1] = pb_in;
  assign pa_out = pin_out_v[0];
  assign pa_oe  = pin_oe_v[0];
  assign pb_out = pin_out_v[1];
  assign pb_oe  = pin_oe_v[1];

  pio_regsel #(.NPORT(NPORT)) u_regsel (
    .clk(clk), .rst_n(rst_n),
    .cs(bus_cs), .en(bus_en), .rw(bus_rw), .rs(bus_rs),
    .route(route),
    .wr_dat(wr_dat), .wr_dir(wr_dir), .wr_ctl(wr_ctl),
    .rd_go(rd_go), .rd_idx(rd_idx), .rd_view(rd_view)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    pio_port #(.W(W)) u_port (
      .clk(clk), .rst_n(rst_n),
      .wr_dat(wr_dat[p]), .wr_dir(wr_dir[p]), .wr_ctl(wr_ctl[p]),
      .wdat(bus_wdata), .pin_in(pin_in_v[p]),
      .pin_out(pin_out_v[p]), .pin_oe(pin_oe_v[p]),
      .view_pins(vpin_v[p]), .view_dir(vdir_v[p]), .view_ctl(vctl_v[p]),
      .route(route[p])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_go) begin
      unique case (rd_view)
        VIEW_PINS: bus_rdata = vpin_v[rd_idx];
        VIEW_DIR:  bus_rdata = vdir_v[rd_idx];
        VIEW_CTRL: bus_rdata = vctl_v[rd_idx];
        default:   bus_rdata = '0;
      endcase
    end
  end

  // R10
  port_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rs[1] == 1'b0) |=> $stable(pb_oe) && $stable(pb_out));
endmodule

// File: tb/pio_dual_port_bench.sv
module pio_dual_port_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       bus_cs = 0, bus_en = 0, bus_rw = 1;
  logic [1:0] bus_rs = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [7:0] pa_in = 0, pb_in = 0;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pio_dual_port u_pio_dual_port (
    .clk(clk), .rst_n(rst_n),
    .bus_cs(bus_cs), .bus_en(bus_en), .bus_rw(bus_rw), .bus_rs(bus_rs),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe)
  );

  // {req[3:0], rd, rs[1:0], wdata, pa, pb, expect}
  localparam int NV = 18;
  localparam logic [38:0] VEC [NV] = '{
    {4'd1,  1'b1, 2'd1, 8'h00, 8'h00, 8'h00, 8'h00}, // R1 ctrl A cleared
    {4'd1,  1'b1, 2'd0, 8'h00, 8'h00, 8'h00, 8'h00}, // R1 dir A cleared
    {4'd3,  1'b0, 2'd0, 8'hF0, 8'h00, 8'h00, 8'h00}, // R3 dir A write
    {4'd3,  1'b1, 2'd0, 8'h00, 8'h00, 8'h00, 8'hF0}, // R3 dir A readback
    {4'd2,  1'b0, 2'd1, 8'h04, 8'h00, 8'h00, 8'h00}, // R2 ctrl A route set
    {4'd2,  1'b1, 2'd1, 8'h00, 8'h00, 8'h00, 8'h04}, // R2 ctrl A readback
    {4'd4,  1'b0, 2'd0, 8'hA5, 8'h00, 8'h00, 8'h00}, // R4 latch A write
    {4'd6,  1'b1, 2'd0, 8'h00, 8'h0F, 8'h00, 8'hAF}, // R6 mixed read
    {4'd6,  1'b1, 2'd0, 8'h00, 8'h03, 8'h00, 8'hA3}, // R6 live pins follow
    {4'd10, 1'b1, 2'd2, 8'h00, 8'h03, 8'h00, 8'h00}, // R10 dir B untouched
    {4'd3,  1'b0, 2'd2, 8'h3C, 8'h03, 8'h00, 8'h00}, // R3 dir B write
    {4'd2,  1'b0, 2'd3, 8'h04, 8'h03, 8'h00, 8'h00}, // R2 ctrl B route set
    {4'd4,  1'b0, 2'd2, 8'hFF, 8'h03, 8'h00, 8'h00}, // R4 latch B write
    {4'd6,  1'b1, 2'd2, 8'h00, 8'h03, 8'h81, 8'hBD}, // R6 port B mixed
    {4'd2,  1'b1, 2'd3, 8'h00, 8'h03, 8'h81, 8'h04}, // R2 ctrl B readback
    {4'd3,  1'b0, 2'd3, 8'h00, 8'h03, 8'h81, 8'h00}, // R3 ctrl B route clear
    {4'd3,  1'b1, 2'd2, 8'h00, 8'h03, 8'h81, 8'h3C}, // R3 dir B again
    {4'd10, 1'b1, 2'd1, 8'h00, 8'h03, 8'h81, 8'h04}  // R10 ctrl A intact
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] rs, input logic [7:0] d);
    @(negedge clk);
    bus_cs = 1; bus_en = 1; bus_rw = 0; bus_rs = rs; bus_wdata = d;
    @(negedge clk);
    bus_cs = 0; bus_en = 0; bus_rw = 1;
  endtask

  task automatic rd(input logic [1:0] rs, output logic [7:0] d);
    @(negedge clk);
    bus_cs = 1; bus_en = 1; bus_rw = 1; bus_rs = rs;
    #1 d = bus_rdata;
    #1 bus_cs = 0; bus_en = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state at the pins
    check("R1 pa_oe", pa_oe, 8'h00);
    check("R1 pb_oe", pb_oe, 8'h00);
    check("R1 pa_out", pa_out, 8'h00);
    rst_n = 1;
    // R8 idle bus reads zero
    #1 check("R8 idle", bus_rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      v = VEC[i];
      pa_in = v[23:16];
      pb_in = v[15:8];
      if (v[34]) begin
        rd(v[33:32], r);
        check($sformatf("R%0d vec %0d", v[38:35], i), r, v[7:0]);
      end else begin
        wr(v[33:32], v[31:24]);
      end
    end

    // R5 pins after table
    #1;
    check("R5 pa_oe", pa_oe, 8'hF0);
    check("R5 pa_out", pa_out, 8'hA0);
    check("R5 pb_oe", pb_oe, 8'h3C);
    check("R5 pb_out", pb_out, 8'h3C);

    // R7 latch loaded while undriven
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h04);
    wr(2'd0, 8'h5A);
    #1 check("R7 hidden out", pa_out, 8'h00);
    check("R7 hidden oe", pa_oe, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hFF);
    #1 check("R7 shown out", pa_out, 8'h5A);
    wr(2'd1, 8'h04);
    pa_in = 8'h00;
    rd(2'd0, r);
    check("R6 all driven", r, 8'h5A);

    // R9 unqualified write attempts
    @(negedge clk);
    bus_cs = 1; bus_en = 0; bus_rw = 0; bus_rs = 2'd1; bus_wdata = 8'hFF;
    @(negedge clk);
    bus_cs = 0; bus_en = 1;
    @(negedge clk);
    bus_en = 0; bus_rw = 1;
    rd(2'd1, r);
    check("R9 ctrl A kept", r, 8'h04);
    #1 check("R9 pins kept", pa_out, 8'h5A);

    // R8 partial qualifiers
    @(negedge clk);
    bus_rs = 2'd0; bus_cs = 0; bus_en = 1; bus_rw = 1;
    #1 check("R8 no cs", bus_rdata, 8'h00);
    bus_cs = 1; bus_en = 0;
    #1 check("R8 no en", bus_rdata, 8'h00);
    bus_en = 1; bus_rw = 0; bus_wdata = 8'h5A;
    #1 check("R8 write cycle", bus_rdata, 8'h00);
    #1 bus_cs = 0; bus_en = 0; bus_rw = 1;

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 0;
    #1 check("R1 async pa_oe", pa_oe, 8'h00);
    check("R1 async pb_out", pb_out, 8'h00);
    @(negedge clk);
    rst_n = 1;
    rd(2'd1, r); check("R1 ctrl A", r, 8'h00);
    rd(2'd0, r); check("R1 dir A", r, 8'h00);
    rd(2'd3, r); check("R1 ctrl B", r, 8'h00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule